// File: doc/BRIEF.md
# Serial Port Sleep and Wake Controller

This block decides when a serial port may stop its internal module clock and its baud clock, and when they must run again. It watches the port's activity flags (receive line level, transmit queue and shifter empty, receive queue empty, pending interrupt sources, transmit queue writes and the modem input pins). When sleep is permitted and every activity flag has stayed quiet for two consecutive cycles, it drops a clock-gate enable that the surrounding logic feeds to its gating cell. The controller itself runs on the free-running clock, so it can see wake events while the rest of the port is frozen.

A wake event (a level change on the receive line, a transmit queue write, a change on any modem pin, or, when transmit wake is enabled, a transmit holding-register interrupt, a transmit DMA request or a transmit status event) raises the enable again. The receive line is handed to the receiver through the same synchronizer used for wake detection, delayed so that the first low bit arrives together with the restored clock. A sticky wake status bit and wake interrupt report a wake from sleep when software has enabled it; software clears them only by dropping that enable. A system idle handshake lets a power manager request idle: the controller acknowledges only once the clocks are stopped, and while idle it turns unmasked events into a sticky wake request instead of a normal interrupt.

Top module: `uart_sleep_wake_ctrl`

## Requirements
- R1: The clock-gate enable `clk_en` is low only when sleep is allowed (`sleep_en`, or `idle_req` with no pending `wake_req`), the synchronized receive line is high, `tx_fifo_empty`, `tx_shift_empty` and `rx_fifo_empty` are all 1, and no bit of `irq_pending` other than bit `THR_IDX` (default 1) is set; a set bit `THR_IDX` alone does not keep the port awake.
- R2: `clk_en` falls only after the sleep condition has held in two consecutive cycles: with every flag quiet from one cycle on, `clk_en` is still 1 after the first clock edge and 0 after the second; a quiet condition lasting a single cycle never drops it.
- R3: A level change on `rx_in` or on any bit of `modem_in` passes two synchronizer flops; `clk_en` returns to 1 on the third clock edge after the change, and `rx_sync` shows the `rx_in` level three edges later, so the changed level appears on `rx_sync` in the same cycle the clock returns.
- R4: A one-cycle `tx_fifo_wr` pulse while asleep sets `clk_en` to 1 on the next clock edge.
- R5: `thr_irq`, `tx_dma_req` and `tx_status_evt` wake the port (next edge) only while `tx_wake_en` is 1; with `tx_wake_en` at 0 they leave `clk_en` low.
- R6: `wake_sts` and `wake_irq` become 1 on the edge after a wake event that occurs while asleep, only if `wake_irq_en` is 1; with `wake_irq_en` at 0 a wake leaves them at 0.
- R7: Once set, `wake_sts` and `wake_irq` stay 1 (also through later sleep and wake cycles) until `wake_irq_en` is 0 at a clock edge, which clears them; setting `wake_irq_en` again does not restore them without a new wake event.
- R8: `idle_ack` is 1 only while `idle_req` is held and the clocks are stopped; it rises on the same edge that `clk_en` falls.
- R9: While `idle_ack` is 1, an unmasked pending interrupt (`irq_pending & irq_mask`) or a wake event sets `wake_req` on the next edge; `wake_req` stays 1 until `idle_req` is 0, it withdraws idle permission, and `irq_out` stays 0 while idle or wake request is active; otherwise `irq_out` is 1 one edge after an unmasked pending interrupt appears.
- R10: After synchronous reset `clk_en` and `rx_sync` are 1 and `wake_sts`, `wake_irq`, `idle_ack`, `wake_req` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Software permission to sleep |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| modem_in | input | N_MODEM | Asynchronous modem input pins |
| tx_fifo_empty | input | 1 | Transmit queue holds no data |
| tx_shift_empty | input | 1 | Transmit shifter is idle |
| rx_fifo_empty | input | 1 | Receive queue holds no data |
| irq_pending | input | N_IRQ | Pending interrupt sources, bit THR_IDX is the transmit holding-register source |
| irq_mask | input | N_IRQ | Per-source interrupt enables |
| tx_fifo_wr | input | 1 | Write strobe into the transmit queue |
| tx_wake_en | input | 1 | Lets transmit-side events wake the port |
| thr_irq | input | 1 | Transmit holding-register interrupt event |
| tx_dma_req | input | 1 | Transmit DMA request |
| tx_status_evt | input | 1 | Transmit status event |
| wake_irq_en | input | 1 | Enable for wake status and wake interrupt |
| idle_req | input | 1 | System idle request |
| clk_en | output | 1 | Clock-gate enable for module and baud clocks |
| rx_sync | output | 1 | Synchronized receive line for the receiver |
| wake_sts | output | 1 | Sticky wake-occurred status |
| wake_irq | output | 1 | Wake interrupt |
| idle_ack | output | 1 | System idle acknowledge |
| wake_req | output | 1 | Wake request to the system while idle |
| irq_out | output | 1 | Normal interrupt line, suppressed while idle |

## Verification
The embedded properties watch, on every cycle, that the enable only falls after two quiet cycles, that a transmit write, a receive edge or an enabled transmit event restores it on the next edge, that the wake status is held while enabled and cleared without it, that acknowledge implies stopped clocks, and that the normal interrupt is silent while a wake request stands. Only the bench scenarios show the full sleep condition across all 128 combinations of the seven idle inputs, the exact three-edge latency from a pin change to the restored clock and the matching arrival of the level on `rx_sync`, the need for a fresh event after re-enabling wake status, and the ordering of acknowledge, wake request and interrupt release across a whole idle handshake.

// File: rtl/uswc_pkg.sv
package uswc_pkg;
  typedef enum logic {
    PWR_RUN   = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_state_t;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/uswc_sync.sv
// Multi-flop synchronizer with one extra stage kept for change detection.
module uswc_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= {W{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q      = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/uswc_sleep_fsm.sv
// Two-cycle qualified sleep state and idle acknowledge.
module uswc_sleep_fsm
  import uswc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic quiet,
  input  logic idle_req,
  output logic asleep,
  output logic idle_ack
);
  pwr_state_t state;
  logic       cond;
  logic       cond_q;
  logic       enter;

  assign cond  = allow & quiet;
  assign enter = cond & cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q   <= 1'b0;
      state    <= PWR_RUN;
      idle_ack <= 1'b0;
    end else begin
      cond_q   <= cond;
      state    <= enter ? PWR_SLEEP : PWR_RUN;
      idle_ack <= idle_req & enter;
    end
  end

  assign asleep = (state == PWR_SLEEP);

  // R8: acknowledge only while stopped and requested
  assert_ack_only_asleep_R8: assert property (@(posedge clk) disable iff (rst)
    idle_ack |-> (asleep && $past(idle_req)));

  // R2: sleep state is left as soon as the condition breaks
  assert_leave_on_break_R2: assert property (@(posedge clk) disable iff (rst)
    (asleep && !cond) |=> !asleep);
endmodule

// File: rtl/uswc_wake_flags.sv
// Sticky wake status, system wake request and gated normal interrupt.
module uswc_wake_flags (
  input  logic clk,
  input  logic rst,
  input  logic asleep,
  input  logic wake_evt,
  input  logic wake_irq_en,
  input  logic idle_req,
  input  logic idle_ack,
  input  logic any_unmasked,
  output logic wake_sts,
  output logic wake_req,
  output logic irq_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_sts <= 1'b0;
      wake_req <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      wake_sts <= wake_irq_en & (wake_sts | (asleep & wake_evt));
      wake_req <= idle_req & (wake_req | (idle_ack & (wake_evt | any_unmasked)));
      irq_out  <= any_unmasked & ~idle_ack & ~wake_req;
    end
  end

  // R7: a disabled enable clears the status on the next edge
  assert_clear_by_enable_R7: assert property (@(posedge clk) disable iff (rst)
    !wake_irq_en |=> !wake_sts);

  // R7: the status holds while its enable stays set
  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_sts && wake_irq_en) |=> wake_sts);

  // R6: status only rises after a wake from sleep
  assert_status_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_sts) |-> $past(asleep && wake_evt && wake_irq_en));

  // R9: normal interrupt silent while a wake request stands
  assert_irq_silent_R9: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> !irq_out);
endmodule

// File: rtl/uart_sleep_wake_ctrl.sv
module uart_sleep_wake_ctrl #(
  parameter int N_MODEM = 4,
  parameter int N_IRQ   = 8,
  parameter int THR_IDX = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_en,
  input  logic               rx_in,
  input  logic [N_MODEM-1:0] modem_in,
  input  logic               tx_fifo_empty,
  input  logic               tx_shift_empty,
  input  logic               rx_fifo_empty,
  input  logic [N_IRQ-1:0]   irq_pending,
  input  logic [N_IRQ-1:0]   irq_mask,
  input  logic               tx_fifo_wr,
  input  logic               tx_wake_en,
  input  logic               thr_irq,
  input  logic               tx_dma_req,
  input  logic               tx_status_evt,
  input  logic               wake_irq_en,
  input  logic               idle_req,
  output logic               clk_en,
  output logic               rx_sync,
  output logic               wake_sts,
  output logic               wake_irq,
  output logic               idle_ack,
  output logic               wake_req,
  output logic               irq_out
);
  import uswc_pkg::*;

  localparam logic [N_IRQ-1:0] THR_ONEHOT = {{(N_IRQ-1){1'b0}}, 1'b1} << THR_IDX;

  logic               rx_s, rx_d;
  logic [N_MODEM-1:0] modem_s, modem_d;
  logic               rx_edge, modem_chg, tx_evt;
  logic               wake_evt, quiet, allow, asleep, any_unmasked;

  uswc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_s), .q_prev(rx_d)
  );

  uswc_sync #(.W(N_MODEM), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_modem_sync (
    .clk(clk), .rst(rst), .d(modem_in), .q(modem_s), .q_prev(modem_d)
  );

  assign rx_edge      = rx_s ^ rx_d;
  assign modem_chg    = |(modem_s ^ modem_d);
  assign tx_evt       = tx_wake_en & (thr_irq | tx_dma_req | tx_status_evt);
  assign wake_evt     = rx_edge | modem_chg | tx_fifo_wr | tx_evt;
  assign any_unmasked = |(irq_pending & irq_mask);

  assign quiet = rx_s & ~wake_evt & tx_fifo_empty & tx_shift_empty & rx_fifo_empty
               & ~|(irq_pending & ~THR_ONEHOT);
  assign allow = sleep_en | (idle_req & ~wake_req);

  uswc_sleep_fsm u_fsm (
    .clk(clk), .rst(rst), .allow(allow), .quiet(quiet), .idle_req(idle_req),
    .asleep(asleep), .idle_ack(idle_ack)
  );

  uswc_wake_flags u_flags (
    .clk(clk), .rst(rst), .asleep(asleep), .wake_evt(wake_evt),
    .wake_irq_en(wake_irq_en), .idle_req(idle_req), .idle_ack(idle_ack),
    .any_unmasked(any_unmasked), .wake_sts(wake_sts), .wake_req(wake_req),
    .irq_out(irq_out)
  );

  assign clk_en   = ~asleep;
  assign rx_sync  = rx_d;
  assign wake_irq = wake_sts;

  // R2: the enable falls only after two quiet cycles
  assert_two_cycle_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> ($past(quiet, 1) && $past(quiet, 2)));

  // R4: a queue write restores the clock on the next edge
  assert_write_wakes_R4: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && tx_fifo_wr) |=> clk_en);

  // R3: a synchronized receive edge restores the clock on the next edge
  assert_rx_edge_wakes_R3: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && rx_edge) |=> clk_en);

  // R5: enabled transmit events restore the clock
  assert_tx_event_wakes_R5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && tx_wake_en && (thr_irq || tx_dma_req || tx_status_evt)) |=> clk_en);

  // R8: acknowledge implies stopped clocks
  assert_ack_clock_off_R8: assert property (@(posedge clk) disable iff (rst)
    idle_ack |-> !clk_en);
endmodule

// File: tb/uart_sleep_wake_ctrl_tb_top.sv
module uart_sleep_wake_ctrl_tb_top;
  localparam int N_MODEM = 4;
  localparam int N_IRQ   = 8;
  localparam int THR_IDX = 1;

  logic clk = 1'b0;
  logic rst;
  logic sleep_en, rx_in, tx_fifo_empty, tx_shift_empty, rx_fifo_empty;
  logic [N_MODEM-1:0] modem_in;
  logic [N_IRQ-1:0] irq_pending, irq_mask;
  logic tx_fifo_wr, tx_wake_en, thr_irq, tx_dma_req, tx_status_evt;
  logic wake_irq_en, idle_req;
  logic clk_en, rx_sync, wake_sts, wake_irq, idle_ack, wake_req, irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_sleep_wake_ctrl #(.N_MODEM(N_MODEM), .N_IRQ(N_IRQ), .THR_IDX(THR_IDX)) dut_i (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .rx_in(rx_in), .modem_in(modem_in),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rx_fifo_empty(rx_fifo_empty), .irq_pending(irq_pending), .irq_mask(irq_mask),
    .tx_fifo_wr(tx_fifo_wr), .tx_wake_en(tx_wake_en), .thr_irq(thr_irq),
    .tx_dma_req(tx_dma_req), .tx_status_evt(tx_status_evt),
    .wake_irq_en(wake_irq_en), .idle_req(idle_req), .clk_en(clk_en),
    .rx_sync(rx_sync), .wake_sts(wake_sts), .wake_irq(wake_irq),
    .idle_ack(idle_ack), .wake_req(wake_req), .irq_out(irq_out)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet_inputs();
    sleep_en = 1'b1; rx_in = 1'b1; tx_fifo_empty = 1'b1; tx_shift_empty = 1'b1;
    rx_fifo_empty = 1'b1; irq_pending = '0; irq_mask = '0; tx_fifo_wr = 1'b0;
    tx_wake_en = 1'b0; thr_irq = 1'b0; tx_dma_req = 1'b0; tx_status_evt = 1'b0;
    idle_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet_inputs();
    sleep_en = 1'b0; modem_in = '0; wake_irq_en = 1'b0;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "clk_en", clk_en, 1'b1);
    chk("R10", "rx_sync", rx_sync, 1'b1);
    chk("R10", "wake_sts", wake_sts, 1'b0);
    chk("R10", "wake_irq", wake_irq, 1'b0);
    chk("R10", "idle_ack", idle_ack, 1'b0);
    chk("R10", "wake_req", wake_req, 1'b0);
    chk("R10", "irq_out", irq_out, 1'b0);

    // R1: sweep all 128 combinations of the seven sleep-condition inputs
    for (int c = 0; c < 128; c++) begin
      logic exp_sleep;
      sleep_en       = c[0];
      rx_in          = c[1];
      tx_fifo_empty  = c[2];
      tx_shift_empty = c[3];
      rx_fifo_empty  = c[4];
      irq_pending    = '0;
      irq_pending[0]       = c[5];
      irq_pending[THR_IDX] = c[6];
      exp_sleep = c[0] & c[1] & c[2] & c[3] & c[4] & ~c[5];
      step(7);
      chk("R1", $sformatf("clk_en combo %0d", c), clk_en, ~exp_sleep);
      chk("R1", $sformatf("idle_ack combo %0d", c), idle_ack, 1'b0);
    end

    // R2: two-cycle qualification
    quiet_inputs();
    tx_fifo_empty = 1'b0;
    step(4);
    chk("R2", "awake while busy", clk_en, 1'b1);
    tx_fifo_empty = 1'b1;
    step(1);
    chk("R2", "after first quiet edge", clk_en, 1'b1);
    step(1);
    chk("R2", "after second quiet edge", clk_en, 1'b0);
    tx_fifo_empty = 1'b0;
    step(3);
    tx_fifo_empty = 1'b1;
    step(1);
    tx_fifo_empty = 1'b0;
    step(1);
    chk("R2", "single quiet cycle a", clk_en, 1'b1);
    step(3);
    chk("R2", "single quiet cycle b", clk_en, 1'b1);

    // R4: transmit queue write wakes on next edge
    quiet_inputs();
    step(6);
    chk("R4", "asleep before write", clk_en, 1'b0);
    tx_fifo_wr = 1'b1;
    step(1);
    chk("R4", "awake after write", clk_en, 1'b1);
    tx_fifo_wr = 1'b0;
    step(1);
    chk("R4", "still awake one edge later", clk_en, 1'b1);
    step(1);
    chk("R4", "asleep again", clk_en, 1'b0);

    // R3: receive line edge, three edges to wake, level arrives with the clock
    step(3);
    rx_in = 1'b0;
    step(2);
    chk("R3", "rx: still asleep after two edges", clk_en, 1'b0);
    chk("R3", "rx_sync still high", rx_sync, 1'b1);
    step(1);
    chk("R3", "rx: awake after third edge", clk_en, 1'b1);
    chk("R3", "rx_sync low with clock", rx_sync, 1'b0);
    rx_in = 1'b1;
    step(8);
    chk("R3", "asleep after rx returns idle", clk_en, 1'b0);
    // R3: modem pin change
    modem_in = 4'b0100;
    step(2);
    chk("R3", "modem: still asleep", clk_en, 1'b0);
    step(1);
    chk("R3", "modem: awake on third edge", clk_en, 1'b1);
    step(6);
    chk("R3", "asleep with steady modem level", clk_en, 1'b0);

    // R5: transmit events need tx_wake_en
    thr_irq = 1'b1;
    step(5);
    chk("R5", "thr_irq ignored without enable", clk_en, 1'b0);
    tx_wake_en = 1'b1;
    step(1);
    chk("R5", "thr_irq wakes with enable", clk_en, 1'b1);
    thr_irq = 1'b0;
    step(6);
    chk("R5", "asleep with enable and no event", clk_en, 1'b0);
    tx_dma_req = 1'b1;
    step(1);
    chk("R5", "dma request wakes", clk_en, 1'b1);
    tx_dma_req = 1'b0;
    step(6);
    tx_status_evt = 1'b1;
    step(1);
    chk("R5", "status event wakes", clk_en, 1'b1);
    tx_status_evt = 1'b0;
    tx_wake_en = 1'b0;
    tx_dma_req = 1'b1;
    step(6);
    chk("R5", "dma request ignored without enable", clk_en, 1'b0);
    tx_dma_req = 1'b0;

    // R6: wake status needs its enable
    chk("R6", "no status from earlier wakes", wake_sts, 1'b0);
    wake_irq_en = 1'b1;
    step(3);
    chk("R6", "no status without event", wake_sts, 1'b0);
    tx_fifo_wr = 1'b1;
    step(1);
    tx_fifo_wr = 1'b0;
    chk("R6", "status set by wake", wake_sts, 1'b1);
    chk("R6", "interrupt set by wake", wake_irq, 1'b1);
    // R7: sticky until enable dropped
    step(8);
    chk("R7", "status held through re-sleep", wake_sts, 1'b1);
    chk("R7", "clock off again", clk_en, 1'b0);
    wake_irq_en = 1'b0;
    step(1);
    chk("R7", "status cleared by enable drop", wake_sts, 1'b0);
    chk("R7", "interrupt cleared by enable drop", wake_irq, 1'b0);
    wake_irq_en = 1'b1;
    step(3);
    chk("R7", "no restore on re-enable", wake_irq, 1'b0);
    tx_fifo_wr = 1'b1;
    step(1);
    tx_fifo_wr = 1'b0;
    chk("R7", "next event caught", wake_irq, 1'b1);
    wake_irq_en = 1'b0;
    step(1);
    // R6: wake with enable off leaves status low
    step(6);
    tx_fifo_wr = 1'b1;
    step(1);
    tx_fifo_wr = 1'b0;
    chk("R6", "wake without enable", wake_sts, 1'b0);

    // R8: idle handshake
    quiet_inputs();
    sleep_en = 1'b0;
    step(6);
    chk("R8", "awake without permission", clk_en, 1'b1);
    chk("R8", "no ack without request", idle_ack, 1'b0);
    idle_req = 1'b1;
    step(1);
    chk("R8", "no ack after first edge", idle_ack, 1'b0);
    chk("R8", "clock on after first edge", clk_en, 1'b1);
    step(1);
    chk("R8", "ack on second edge", idle_ack, 1'b1);
    chk("R8", "clock off with ack", clk_en, 1'b0);

    // R9: unmasked interrupt during idle becomes wake request
    irq_pending[THR_IDX] = 1'b1;
    irq_mask[THR_IDX]    = 1'b1;
    step(1);
    chk("R9", "wake_req raised", wake_req, 1'b1);
    chk("R9", "irq_out held low", irq_out, 1'b0);
    step(1);
    chk("R9", "clock restored", clk_en, 1'b1);
    chk("R9", "ack withdrawn", idle_ack, 1'b0);
    chk("R9", "irq_out still low", irq_out, 1'b0);
    step(3);
    chk("R9", "wake_req sticky", wake_req, 1'b1);
    chk("R9", "no re-sleep while requested", clk_en, 1'b1);
    idle_req = 1'b0;
    step(1);
    chk("R9", "wake_req cleared", wake_req, 1'b0);
    chk("R9", "irq_out low one edge after", irq_out, 1'b0);
    step(1);
    chk("R9", "irq_out released", irq_out, 1'b1);
    irq_mask = '0;
    step(1);
    chk("R9", "masked source gives no irq", irq_out, 1'b0);
    // R9: wake event during idle
    irq_pending = '0;
    idle_req = 1'b1;
    step(3);
    chk("R8", "ack again", idle_ack, 1'b1);
    tx_fifo_wr = 1'b1;
    step(1);
    tx_fifo_wr = 1'b0;
    chk("R9", "wake_req from queue write", wake_req, 1'b1);
    chk("R9", "clock back from queue write", clk_en, 1'b1);
    idle_req = 1'b0;
    step(2);
    chk("R9", "wake_req gone", wake_req, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule